// File: doc/BRIEF.md
# Address Translation Cache with Address-Space Tags

This block caches recently used translations from virtual page number to physical frame number. Every entry also carries the address-space identifier of the process that owns it. A lookup compares the requested page number and the current identifier against every entry at once. It answers in the same cycle with a hit and the frame number, or with a miss. On a miss, an external page-table walker fetches the translation from memory and hands it back through the fill port.

Translations that belong to different processes stay in the cache side by side, so a context switch does not require invalidation. Software-driven invalidation is still available in two forms: one clears every entry, and the other clears only the entries of one identifier.

A fill goes to the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the victim. A fill whose page and identifier are already cached rewrites that entry in place.

Top module: `tlb_asid_top`

## Requirements
- R1: `lk_hit` and `lk_miss` are both 0 when `lk_req` is 0. When `lk_req` is 1, exactly one of them is 1 in the same cycle. `lk_pfn` is 0 whenever `lk_hit` is 0.
- R2: A lookup hits only when an entry is valid and both its page number and its identifier equal `lk_vpn` and `lk_asid`. `lk_pfn` is then the frame number stored in that entry.
- R3: The same page number can be cached under different identifiers at the same time, and each returns its own frame number.
- R4: A fill that creates a new entry uses the lowest-numbered invalid entry, as long as one exists.
- R5: When all entries are valid, a new fill replaces the entry the round-robin pointer selects. The pointer is 0 after reset and advances by one, wrapping at ENTRIES-1, only on such a replacement.
- R6: A fill whose page number and identifier match a valid entry replaces that entry's frame number. It takes no further entry and does not move the pointer.
- R7: A cycle with `flush_all` high clears every entry, so every lookup in the next cycle misses.
- R8: A cycle with `flush_asid_en` high clears exactly the entries whose identifier equals `flush_asid` and leaves all others intact.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill. The fill becomes visible to lookups one cycle later.
- R10: A fill presented in a cycle where either flush input is high is discarded.
- R11: After a synchronous active-low reset, all entries are invalid and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_pfn | output | PFN_W | Frame number on hit, 0 otherwise |
| fl_valid | input | 1 | Install a walker result this cycle |
| fl_vpn | input | VPN_W | Page number to install |
| fl_asid | input | ASID_W | Identifier to install |
| fl_pfn | input | PFN_W | Frame number to install |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
The bench builds the block with 4 entries, 6-bit page and frame numbers and 2-bit identifiers. Because the key space is that small, every page and identifier pair (256 lookups) is swept after each phase and compared against an arithmetic model of the entries. At this size the cache fills after four installs, so the round-robin pointer wraps several times within a short run. The bench also fills holes left by an identifier flush and covers the same-cycle fill cases, both with lookups and with flushes.

// File: rtl/tlb_pkg.sv
// Shared types for the translation cache.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tlb_pkg;
    // How a fill is placed into the entry array.
    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_UPDATE = 2'd1,
        FILL_FREE   = 2'd2,
        FILL_EVICT  = 2'd3
    } fill_kind_e;
endpackage

// File: rtl/tlb_match.sv
// Parallel comparator: flags every valid entry whose page number and
// identifier equal the presented key. Purely combinational.
// Assumes the caller keeps at most one entry per key.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             valid_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match_vec
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // One comparator per entry.
        assign match_vec[i] = valid_vec[i] && (ent_vpn[i] == key_vpn)
                              && (ent_asid[i] == key_asid);
    end
endmodule

// File: rtl/tlb_victim.sv
// Chooses where a fill lands: the matching entry, the lowest invalid
// entry, or the round-robin victim. Owns the replacement pointer.
// Assumes ENTRIES >= 2 and upd_vec is one-hot or zero.
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_go,
    input  logic [ENTRIES-1:0]   valid_vec,
    input  logic [ENTRIES-1:0]   upd_vec,
    output tlb_pkg::fill_kind_e  kind,
    output logic [IDX_W-1:0]     idx
);
    import tlb_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] upd_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Encode the matching entry and the lowest invalid entry.
    always_comb begin
        upd_idx  = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (upd_vec[i]) upd_idx = IDX_W'(i);
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Placement decision in priority order: update, free slot, evict.
    always_comb begin
        if (!fill_go) begin
            kind = FILL_NONE;
            idx  = '0;
        end else if (|upd_vec) begin
            kind = FILL_UPDATE;
            idx  = upd_idx;
        end else if (any_free) begin
            kind = FILL_FREE;
            idx  = free_idx;
        end else begin
            kind = FILL_EVICT;
            idx  = ptr_q;
        end
    end

    // Round-robin pointer moves only on an eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (kind == FILL_EVICT) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_store.sv
// Entry storage: valid bits plus page, identifier and frame fields.
// Flushes act on the valid bits; one entry is written per cycle.
// Assumes the caller never writes in a cycle that flushes.
module tlb_store #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VPN_W-1:0]               wr_vpn,
    input  logic [ASID_W-1:0]              wr_asid,
    input  logic [PFN_W-1:0]               wr_pfn,
    input  logic                           clr_all,
    input  logic                           clr_asid_en,
    input  logic [ASID_W-1:0]              clr_asid,
    output logic [ENTRIES-1:0]             valid_vec,
    output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    output logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    output logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        // Valid bit: reset and flush clear it, a write sets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
            end else if (clr_all || (clr_asid_en && ent_asid[i] == clr_asid)) begin
                valid_vec[i] <= 1'b0;
            end else if (sel) begin
                valid_vec[i] <= 1'b1;
            end
        end

        // Payload fields: loaded on a write, held otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vpn[i]  <= '0;
                ent_asid[i] <= '0;
                ent_pfn[i]  <= '0;
            end else if (sel) begin
                ent_vpn[i]  <= wr_vpn;
                ent_asid[i] <= wr_asid;
                ent_pfn[i]  <= wr_pfn;
            end
        end
    end
endmodule

// File: rtl/tlb_asid_top.sv
// Fully associative translation cache with identifier-tagged entries.
// Lookup is combinational on registered state; fills and flushes take
// effect at the next edge. A flush in the same cycle drops the fill.
// Assumes ENTRIES >= 2.
module tlb_asid_top #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    import tlb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
    logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
    logic [ENTRIES-1:0]             hit_vec;
    logic [ENTRIES-1:0]             upd_vec;
    logic                           fill_go;
    fill_kind_e                     kind;
    logic [IDX_W-1:0]               wr_idx;
    logic [PFN_W-1:0]               pfn_or;

    assign fill_go = fl_valid && !flush_all && !flush_asid_en;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .valid_vec (valid_vec),
        .ent_vpn   (ent_vpn),
        .ent_asid  (ent_asid),
        .key_vpn   (lk_vpn),
        .key_asid  (lk_asid),
        .match_vec (hit_vec)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
        .valid_vec (valid_vec),
        .ent_vpn   (ent_vpn),
        .ent_asid  (ent_asid),
        .key_vpn   (fl_vpn),
        .key_asid  (fl_asid),
        .match_vec (upd_vec)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_go   (fill_go),
        .valid_vec (valid_vec),
        .upd_vec   (upd_vec),
        .kind      (kind),
        .idx       (wr_idx)
    );

    tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (kind != FILL_NONE),
        .wr_idx      (wr_idx),
        .wr_vpn      (fl_vpn),
        .wr_asid     (fl_asid),
        .wr_pfn      (fl_pfn),
        .clr_all     (flush_all),
        .clr_asid_en (flush_asid_en),
        .clr_asid    (flush_asid),
        .valid_vec   (valid_vec),
        .ent_vpn     (ent_vpn),
        .ent_asid    (ent_asid),
        .ent_pfn     (ent_pfn)
    );

    // AND-OR frame mux; at most one hit line is active.
    always_comb begin
        pfn_or = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            pfn_or = pfn_or | (ent_pfn[i] & {PFN_W{hit_vec[i]}});
        end
    end

    assign lk_hit  = lk_req && (|hit_vec);
    assign lk_miss = lk_req && !(|hit_vec);
    assign lk_pfn  = lk_hit ? pfn_or : '0;
endmodule

// File: rtl/tlb_asid_chk.sv
// Property checker for tlb_asid_top, attached with bind below.
// Assumes it sees the top's ports plus its hit and valid vectors.
module tlb_asid_chk #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic              fl_valid,
    input logic [VPN_W-1:0]  fl_vpn,
    input logic [ASID_W-1:0] fl_asid,
    input logic [PFN_W-1:0]  fl_pfn,
    input logic              flush_all,
    input logic              flush_asid_en,
    input logic [ASID_W-1:0] flush_asid,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_vec
);
    logic seen;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> (lk_hit != lk_miss));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss && lk_pfn == '0));
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    a_r7_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(flush_all)) |-> (valid_vec == '0));
    a_r8_flush_asid: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(flush_asid_en) && lk_req && lk_asid == $past(flush_asid)
         && !($past(fl_valid) && !$past(flush_asid_en))) |-> !lk_hit);
    a_r9_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(fl_valid && !flush_all && !flush_asid_en) && lk_req
         && lk_vpn == $past(fl_vpn) && lk_asid == $past(fl_asid))
        |-> (lk_hit && lk_pfn == $past(fl_pfn)));
    a_r11_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (valid_vec == '0));
endmodule

bind tlb_asid_top tlb_asid_chk #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_pfn(fl_pfn),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_asid(flush_asid), .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/tb_tlb_asid_top.sv
// Bench: 4-entry configuration, full key sweeps against an arithmetic model.
module tb_tlb_asid_top;
    localparam int E  = 4;
    localparam int VW = 6;
    localparam int PW = 6;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_req = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic          lk_hit, lk_miss;
    logic [PW-1:0] lk_pfn;
    logic          fl_valid = 1'b0;
    logic [VW-1:0] fl_vpn = '0;
    logic [AW-1:0] fl_asid = '0;
    logic [PW-1:0] fl_pfn = '0;
    logic          flush_all = 1'b0;
    logic          flush_asid_en = 1'b0;
    logic [AW-1:0] flush_asid = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model of the entries.
    bit            m_v [E];
    int            m_vpn [E];
    int            m_asid [E];
    int            m_pfn [E];
    int            m_ptr;

    always #4 clk = ~clk;

    tlb_asid_top #(.ENTRIES(E), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_pfn(fl_pfn),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    function automatic int m_find(int v, int a);
        for (int i = 0; i < E; i++)
            if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
        return -1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Single lookup, checked against the model in the same cycle.
    task automatic look(string req, int v, int a);
        int k;
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = VW'(v); lk_asid = AW'(a);
        #1;
        k = m_find(v, a);
        check(req, {lk_hit, lk_miss}, (k >= 0) ? 2 : 1);
        check(req, int'(lk_pfn), (k >= 0) ? m_pfn[k] : 0);
        lk_req = 1'b0;
    endtask

    // Exhaustive sweep over every page and identifier.
    task automatic sweep(string req);
        for (int a = 0; a < (1 << AW); a++)
            for (int v = 0; v < (1 << VW); v++)
                look(req, v, a);
    endtask

    // One fill cycle, optionally with flushes; model follows the rules.
    task automatic fill(int v, int a, int p, bit fa, bit fe, int fasid);
        int k;
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = VW'(v); fl_asid = AW'(a); fl_pfn = PW'(p);
        flush_all = fa; flush_asid_en = fe; flush_asid = AW'(fasid);
        @(posedge clk);
        if (fa || fe) begin
            for (int i = 0; i < E; i++)
                if (fa || m_asid[i] == fasid) m_v[i] = 1'b0;
        end else begin
            k = m_find(v, a);
            if (k < 0)
                for (int i = E - 1; i >= 0; i--) if (!m_v[i]) k = i;
            if (k < 0) begin
                k = m_ptr;
                m_ptr = (m_ptr + 1) % E;
            end
            m_v[k] = 1'b1; m_vpn[k] = v; m_asid[k] = a; m_pfn[k] = p;
        end
        @(negedge clk);
        fl_valid = 1'b0; flush_all = 1'b0; flush_asid_en = 1'b0;
    endtask

    task automatic flush_only(bit fa, int fasid);
        @(negedge clk);
        flush_all = fa; flush_asid_en = !fa; flush_asid = AW'(fasid);
        @(posedge clk);
        for (int i = 0; i < E; i++)
            if (fa || m_asid[i] == fasid) m_v[i] = 1'b0;
        @(negedge clk);
        flush_all = 1'b0; flush_asid_en = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < E; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: everything misses after reset.
        sweep("R11");

        // R1: no request gives no answer even for a cached page.
        fill(5, 1, 33, 0, 0, 0);
        @(negedge clk);
        lk_req = 1'b0; lk_vpn = 6'd5; lk_asid = 2'd1;
        #1;
        check("R1", {lk_hit, lk_miss}, 0);
        check("R1", int'(lk_pfn), 0);

        // R2 R3 R4: same page under several identifiers, filling free slots.
        fill(5, 2, 44, 0, 0, 0);
        fill(5, 0, 12, 0, 0, 0);
        fill(63, 3, 63, 0, 0, 0);
        sweep("R3");

        // R6: in-place update keeps the other entries.
        fill(5, 2, 7, 0, 0, 0);
        sweep("R6");

        // R5: full cache, victims in round-robin order from entry 0.
        fill(10, 1, 1, 0, 0, 0);
        fill(11, 1, 2, 0, 0, 0);
        sweep("R5");

        // R8: identifier flush leaves other identifiers intact.
        flush_only(0, 1);
        sweep("R8");

        // R4: the hole left behind is refilled first.
        fill(20, 3, 9, 0, 0, 0);
        sweep("R4");

        // R9: same-cycle lookup sees the pre-fill contents.
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = 6'd40; fl_asid = 2'd2; fl_pfn = 6'd17;
        lk_req = 1'b1; lk_vpn = 6'd40; lk_asid = 2'd2;
        #1;
        check("R9", {lk_hit, lk_miss}, 1);
        @(posedge clk);
        begin
            int k;
            k = -1;
            for (int i = E - 1; i >= 0; i--) if (!m_v[i]) k = i;
            if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % E; end
            m_v[k] = 1'b1; m_vpn[k] = 40; m_asid[k] = 2; m_pfn[k] = 17;
        end
        @(negedge clk);
        fl_valid = 1'b0;
        #1;
        check("R9", {lk_hit, lk_miss}, 2);
        check("R9", int'(lk_pfn), 17);
        lk_req = 1'b0;

        // R10: fills that coincide with a flush are dropped.
        fill(50, 0, 21, 0, 1, 3);
        look("R10", 50, 0);
        fill(51, 1, 22, 1, 0, 0);
        sweep("R10");

        // R7: full flush after refilling.
        fill(1, 1, 1, 0, 0, 0);
        fill(2, 2, 2, 0, 0, 0);
        flush_only(1, 0);
        sweep("R7");

        // R2 R5 R6: pseudo-random fills with periodic sweeps.
        lfsr = 16'hACE1;
        for (int n = 0; n < 48; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:13] == 3'd0) flush_only(0, int'(lfsr[1:0]));
            else fill(int'(lfsr[5:3]), int'(lfsr[7:6]), int'(lfsr[12:7]), 0, 0, 0);
            if (n % 8 == 7) sweep("R2");
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule